// File: doc/BRIEF.md
# Inductive Reuse Input Port

This block is a small input queue in front of a compute datapath. A producer such as a memory reader or an inter-stream transfer bus writes values into it over a valid/ready channel. The datapath reads from it over a second valid/ready channel. Each stored value carries a set of per-lane predicate bits, which travel in a companion queue that moves in lockstep with the data.

In plain mode, every read removes the value at the head. In reuse mode, the head value is offered several times and is only removed after a given number of reads. That number comes from a fixed-point accumulator with four fractional bits. The accumulator starts at the configured repeat count. After each value is retired, a signed stretch is added to it. The integer part of the accumulator is the repeat count for the next value, and the fractional part carries forward. This lets one configuration describe a consumption pattern that shrinks or grows with a loop index, including a fractional rate of change.

A configuration load gives the mode, the repeat count, the stretch and the number of values the stream will deliver. After that many values have been retired, the port raises a done pulse and goes back to idle.

Top module: `irp_port`

## Requirements
- R1: While reset is held, `rd_valid`, `wr_ready`, `active` and `done` are all low.
- R2: A `cfg_load` seen while idle with a non-zero `cfg_total` makes `active` high on the next cycle and empties both queues. A `cfg_load` seen while active is ignored and changes none of the running parameters.
- R3: `wr_ready` is high exactly when the port is active and holds fewer than DEPTH (default 4) values. `rd_valid` is high exactly when the port is active and holds at least one value.
- R4: With `cfg_reuse` low, every accepted read retires the head value, and values leave in arrival order.
- R5: With `cfg_reuse` high, the head value is presented for exactly N accepted reads and then retired. N is the integer part of the accumulator, and the accumulator is loaded with `cfg_repeat` multiplied by 16.
- R6: Each retirement in reuse mode adds `cfg_stretch` to the accumulator. The stretch is a two's-complement value with 4 fractional bits (16 means +1.0). The fractional remainder is kept for later values.
- R7: When the integer part of the accumulator (rounded towards minus infinity) is zero or negative, each value is read exactly once.
- R8: `rd_pred` always shows the predicate bits that were written together with the value shown on `rd_data`.
- R9: In the cycle after the `cfg_total`-th retirement, `done` is high for one cycle, while `active` and `rd_valid` are low.
- R10: A `cfg_load` seen while idle with `cfg_total` equal to zero leaves the port idle and pulses `done` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Load the stream parameters (taken only when idle) |
| cfg_reuse | input | 1 | 1 selects reuse mode, 0 selects plain mode |
| cfg_repeat | input | CNT_W | Initial repeat count, integer |
| cfg_stretch | input | CNT_W+4 | Signed repeat-count increment per retired value, 4 fractional bits |
| cfg_total | input | LEN_W | Number of values the stream delivers |
| wr_valid | input | 1 | Producer offers a value |
| wr_ready | output | 1 | Port accepts a value |
| wr_data | input | DATA_W | Value written |
| wr_pred | input | LANES | Per-lane predicate bits written with the value |
| rd_valid | output | 1 | Head value is available |
| rd_ready | input | 1 | Datapath consumes the presented value |
| rd_data | output | DATA_W | Head value |
| rd_pred | output | LANES | Predicate bits of the head value |
| active | output | 1 | A stream is in progress |
| done | output | 1 | One-cycle pulse after the last value is retired |

## Verification
The hardest case to reach is the one where the accumulator has gone to zero or below while still carrying a fractional part. In that case the clamp and the carried fraction act together, and a fault in either only shows up several values later. The stimulus uses a shrinking stretch of -1.5 and a whole stretch of -1, so the accumulator drops through fractional and negative values within one stream. It also uses a growing stretch of +0.25, where the count only steps up every fourth value. In every case, the read and write sides are throttled by irregular patterns, so retirements happen when the queue is full, when it is nearly empty, and while a write is arriving.

// File: rtl/irp_pkg.sv
package irp_pkg;
  // fractional bits of the reuse accumulator and of the stretch
  localparam int FRAC_W = 4;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_t;
endpackage

// File: rtl/irp_fifo.sv
module irp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, wp_n, rp_q, rp_n;

  always_comb begin
    wp_n = wp_q;
    rp_n = rp_q;
    if (flush) begin
      wp_n = '0;
      rp_n = '0;
    end else begin
      if (push) wp_n = wp_q + 1'b1;
      if (pop)  rp_n = rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_n;
      rp_q <= rp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q[AW-1:0]] <= din;
  end

  assign level = wp_q - rp_q;
  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW-1:0] == rp_q[AW-1:0]) && (wp_q[AW] != rp_q[AW]);
  assign dout  = mem[rp_q[AW-1:0]];
endmodule

// File: rtl/irp_reuse_ctl.sv
module irp_reuse_ctl #(
  parameter int CNT_W = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   load,
  input  logic                                   load_reuse,
  input  logic [CNT_W-1:0]                       load_repeat,
  input  logic [CNT_W+irp_pkg::FRAC_W-1:0]       load_stretch,
  input  logic                                   read,
  output logic                                   retire,
  output logic [CNT_W+1:0]                       served,
  output logic [CNT_W+1:0]                       eff
);
  localparam int FW    = irp_pkg::FRAC_W;
  localparam int IW    = CNT_W + 2;
  localparam int ACC_W = IW + FW;
  localparam int STR_W = CNT_W + FW;

  logic [ACC_W-1:0] acc_q, acc_n;
  logic [STR_W-1:0] str_q, str_n;
  logic [IW-1:0]    srv_q, srv_n;
  logic             reuse_q, reuse_n;
  logic [IW-1:0]    whole;

  // integer part, floor for negative values
  assign whole  = acc_q[ACC_W-1:FW];
  assign eff    = (whole[IW-1] || (whole == '0)) ? IW'(1) : whole;
  assign retire = read && (!reuse_q || ((srv_q + IW'(1)) >= eff));
  assign served = srv_q;

  always_comb begin
    acc_n   = acc_q;
    str_n   = str_q;
    srv_n   = srv_q;
    reuse_n = reuse_q;
    if (load) begin
      acc_n   = {2'b00, load_repeat, {FW{1'b0}}};
      str_n   = load_stretch;
      srv_n   = '0;
      reuse_n = load_reuse;
    end else if (retire) begin
      srv_n = '0;
      acc_n = acc_q + {{2{str_q[STR_W-1]}}, str_q};
    end else if (read) begin
      srv_n = srv_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      str_q   <= '0;
      srv_q   <= '0;
      reuse_q <= 1'b0;
    end else begin
      acc_q   <= acc_n;
      str_q   <= str_n;
      srv_q   <= srv_n;
      reuse_q <= reuse_n;
    end
  end
endmodule

// File: rtl/irp_port.sv
module irp_port #(
  parameter int DATA_W = 16,
  parameter int LANES  = 4,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 8,
  parameter int LEN_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_load,
  input  logic                              cfg_reuse,
  input  logic [CNT_W-1:0]                  cfg_repeat,
  input  logic [CNT_W+irp_pkg::FRAC_W-1:0]  cfg_stretch,
  input  logic [LEN_W-1:0]                  cfg_total,
  input  logic                              wr_valid,
  output logic                              wr_ready,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [LANES-1:0]                  wr_pred,
  output logic                              rd_valid,
  input  logic                              rd_ready,
  output logic [DATA_W-1:0]                 rd_data,
  output logic [LANES-1:0]                  rd_pred,
  output logic                              active,
  output logic                              done
);
  import irp_pkg::*;
  localparam int LVL_W = $clog2(DEPTH) + 1;
  localparam int CW    = CNT_W + 2;

  // reset: asserted asynchronously, released after two clock edges
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  phase_t           ph_q, ph_n;
  logic [LEN_W-1:0] remain_q, remain_n;
  logic             done_q, done_n;
  logic             load_ok, push, read, retire;
  logic             full_d, empty_d, full_p, empty_p;
  logic [LVL_W-1:0] lvl_d, lvl_p;
  logic [CW-1:0]    served, eff;

  assign active   = (ph_q == PH_RUN);
  assign load_ok  = cfg_load && !active;
  assign wr_ready = active && !full_d;
  assign push     = wr_valid && wr_ready;
  assign rd_valid = active && !empty_d;
  assign read     = rd_valid && rd_ready;
  assign done     = done_q;

  irp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_data_q (
    .clk(clk), .rst_n(rst_sync_n), .flush(load_ok), .push(push), .din(wr_data),
    .pop(retire), .dout(rd_data), .full(full_d), .empty(empty_d), .level(lvl_d)
  );

  irp_fifo #(.W(LANES), .DEPTH(DEPTH)) u_pred_q (
    .clk(clk), .rst_n(rst_sync_n), .flush(load_ok), .push(push), .din(wr_pred),
    .pop(retire), .dout(rd_pred), .full(full_p), .empty(empty_p), .level(lvl_p)
  );

  irp_reuse_ctl #(.CNT_W(CNT_W)) u_reuse (
    .clk(clk), .rst_n(rst_sync_n), .load(load_ok), .load_reuse(cfg_reuse),
    .load_repeat(cfg_repeat), .load_stretch(cfg_stretch), .read(read),
    .retire(retire), .served(served), .eff(eff)
  );

  always_comb begin
    ph_n     = ph_q;
    remain_n = remain_q;
    done_n   = 1'b0;
    if (load_ok) begin
      remain_n = cfg_total;
      if (cfg_total == '0) done_n = 1'b1;
      else                 ph_n   = PH_RUN;
    end else if (retire) begin
      remain_n = remain_q - 1'b1;
      if (remain_q == LEN_W'(1)) begin
        ph_n   = PH_IDLE;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ph_q     <= PH_IDLE;
      remain_q <= '0;
      done_q   <= 1'b0;
    end else begin
      ph_q     <= ph_n;
      remain_q <= remain_n;
      done_q   <= done_n;
    end
  end
endmodule

// File: rtl/irp_port_chk.sv
module irp_port_chk #(
  parameter int LVL_W = 3,
  parameter int CW    = 10,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             done,
  input logic             rd_valid,
  input logic             wr_ready,
  input logic             full_d,
  input logic             full_p,
  input logic             push,
  input logic             cfg_load,
  input logic             retire,
  input logic [LVL_W-1:0] lvl_d,
  input logic [LVL_W-1:0] lvl_p,
  input logic [CW-1:0]    served,
  input logic [CW-1:0]    eff,
  input logic [LEN_W-1:0] remain
);
  p_lockstep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_d == lvl_p) && (full_d == full_p));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full_d |-> !push);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!rd_valid && !wr_ready));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);

  p_count_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eff != '0);

  p_served_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (served < eff));

  p_busy_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cfg_load && !retire) |=> $stable(remain));
endmodule

bind irp_port irp_port_chk #(
  .LVL_W($clog2(DEPTH) + 1), .CW(CNT_W + 2), .LEN_W(LEN_W)
) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .active(active), .done(done),
  .rd_valid(rd_valid), .wr_ready(wr_ready), .full_d(full_d), .full_p(full_p),
  .push(push), .cfg_load(cfg_load), .retire(retire), .lvl_d(lvl_d),
  .lvl_p(lvl_p), .served(served), .eff(eff), .remain(remain_q)
);

// File: tb/test_irp_port.sv
`timescale 1ns/1ps
module test_irp_port;
  localparam int DATA_W = 16;
  localparam int LANES  = 4;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = 8;
  localparam int LEN_W  = 16;
  localparam int STR_W  = CNT_W + 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_load, cfg_reuse, wr_valid, rd_ready;
  logic [CNT_W-1:0] cfg_repeat;
  logic signed [STR_W-1:0] cfg_stretch;
  logic [LEN_W-1:0] cfg_total;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [LANES-1:0] wr_pred, rd_pred;
  logic wr_ready, rd_valid, active, done;

  always #10 clk = ~clk;

  irp_port #(.DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)) i_irp_port (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_reuse(cfg_reuse),
    .cfg_repeat(cfg_repeat), .cfg_stretch(cfg_stretch), .cfg_total(cfg_total),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_pred(wr_pred),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_pred(rd_pred),
    .active(active), .done(done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  string cur_tag  = "R4";
  string done_tag = "R9";

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [DATA_W+LANES-1:0] q[$];
  bit m_active, m_done, m_reuse, finished, started;
  int m_acc, m_str, m_rem, m_served, wr_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_active = 0; m_done = 0; m_reuse = 0;
      m_acc = 0; m_str = 0; m_rem = 0; m_served = 0; wr_idx = 0;
    end else begin
      bit a0, rdy_w, val_r;
      int eff;
      a0    = m_active;
      rdy_w = a0 && (q.size() < DEPTH);
      val_r = a0 && (q.size() > 0);
      m_done = 0;
      if (val_r && rd_ready) begin
        m_served++;
        eff = m_acc >>> 4;
        if (eff < 1) eff = 1;
        if (!m_reuse || m_served >= eff) begin
          void'(q.pop_front());
          m_served = 0;
          m_acc += m_str;
          m_rem--;
          if (m_rem == 0) begin m_active = 0; m_done = 1; finished = 1; end
        end
      end
      if (rdy_w && wr_valid) begin
        q.push_back({wr_pred, wr_data});
        wr_idx++;
      end
      if (cfg_load && !a0) begin
        q.delete();
        m_acc = int'(cfg_repeat) * 16;
        m_str = int'(cfg_stretch);
        m_reuse = cfg_reuse;
        m_rem = int'(cfg_total);
        m_served = 0;
        wr_idx = 0;
        if (cfg_total == 0) begin m_done = 1; finished = 1; end
        else m_active = 1;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      bit ev, er;
      ev = m_active && (q.size() > 0);
      er = m_active && (q.size() < DEPTH);
      check("R2", active === m_active, int'(active), int'(m_active));
      check("R3", wr_ready === er, int'(wr_ready), int'(er));
      check("R3", rd_valid === ev, int'(rd_valid), int'(ev));
      check(done_tag, done === m_done, int'(done), int'(m_done));
      if (ev && rd_valid) begin
        check(cur_tag, rd_data === q[0][DATA_W-1:0], int'(rd_data), int'(q[0][DATA_W-1:0]));
        check("R8", rd_pred === q[0][DATA_W+LANES-1:DATA_W], int'(rd_pred),
              int'(q[0][DATA_W+LANES-1:DATA_W]));
      end
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run(input bit reuse, input int rep, input int str, input int total,
                     input string tag, input bit busy_load);
    int cyc;
    int base;
    cur_tag  = tag;
    done_tag = (total == 0) ? "R10" : "R9";
    base = (tag.len() > 0) ? 256 * int'(tag[1]) : 0;
    @(negedge clk);
    finished    = 0;
    wr_valid    = 0;
    rd_ready    = 0;
    cfg_load    = 1;
    cfg_reuse   = reuse;
    cfg_repeat  = CNT_W'(rep);
    cfg_stretch = STR_W'(str);
    cfg_total   = LEN_W'(total);
    @(negedge clk);
    cfg_load = 0;
    cyc = 0;
    while (!finished && cyc < 2000) begin
      step_lfsr();
      rd_ready = lfsr[0] | lfsr[3];
      wr_valid = (wr_idx < total) && (lfsr[1] | lfsr[5]);
      wr_data  = DATA_W'(base + wr_idx * 7 + 1);
      wr_pred  = LANES'(wr_idx ^ 5);
      // R2: a load while busy must be ignored
      if (busy_load && cyc == 6) begin
        cfg_load = 1; cfg_reuse = 0; cfg_repeat = 8'd9; cfg_stretch = 12'sd0; cfg_total = 16'd2;
      end else cfg_load = 0;
      cyc++;
      @(negedge clk);
    end
    cfg_load = 0; wr_valid = 0; rd_ready = 0;
    repeat (3) @(negedge clk);
    // R9 / R10: port back to idle
    check(done_tag, !active && !done, int'(active), 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        while (wd < 100000) begin @(posedge clk); wd++; end
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    join_none
  end

  initial begin
    started = 0; finished = 0;
    rst_n = 0; cfg_load = 0; cfg_reuse = 0; cfg_repeat = '0; cfg_stretch = '0;
    cfg_total = '0; wr_valid = 0; rd_ready = 0; wr_data = '0; wr_pred = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    check("R1", rd_valid === 1'b0, int'(rd_valid), 0);
    check("R1", wr_ready === 1'b0, int'(wr_ready), 0);
    check("R1", active === 1'b0, int'(active), 0);
    check("R1", done === 1'b0, int'(done), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    started = 1;
    run(0, 3, 0, 7, "R4", 0);        // plain mode, repeat ignored
    run(1, 3, 0, 5, "R5", 0);        // constant reuse of 3
    run(1, 5, -24, 4, "R6", 0);      // shrink by 1.5: 5,3,2,1
    run(1, 1, 4, 9, "R6", 0);        // grow by 0.25
    run(1, 2, -16, 6, "R7", 0);      // falls to zero and below
    run(1, 0, -8, 3, "R7", 0);       // zero start, fractional negative
    run(0, 0, 0, 0, "R10", 0);       // empty stream
    run(1, 2, 8, 6, "R2", 1);        // load while busy ignored
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule